// File: doc/BRIEF.md
# DAC Setting Store with Nonvolatile Shadows

This block keeps the settings of a one- or two-channel digital-to-analog converter controller. Every channel has a DAC code, a reference-select field, a power-down field and a gain bit. Each of them exists twice: a working copy that drives the converter and a shadow copy that stands in for nonvolatile memory. The shadow copies survive a warm reset. When the warm reset is asserted, each working copy is reloaded from its shadow. A 7-bit bus address is kept in the nonvolatile area only. A status word holds a write-lock bit and a busy flag, and exists only as a working register.

A serial front end, which is not part of this block, reaches a 32-word by 16-bit space through a plain synchronous port: one write strobe, one read strobe, one address and one data word each way. A write to a shadow location is not applied at once. It is held, a busy flag rises for a parameterised number of cycles, and the value is committed when the flag falls. This models the time that nonvolatile memory takes to program. The lock bit refuses every shadow write.

The output buses carry each channel's effective code and its analog-control bits. The gain presented to the analog side obeys a legality rule: doubling is never applied while the supply is the reference.

Top module: `dac_cfg_bank`

## Requirements
- R1: While `por_n` is low, and after it rises, every DAC code (working and shadow) equals 2^(RES_BITS-1)-1: 7Fh, 1FFh or 7FFh for 8, 10 or 12 bits. Every reference, power-down and gain field is 0, `nv_busy` is 0, the lock bit is 0, `slave_addr` is 60h and `rdata` is 0.
- R2: A write to address 00h+c (channel c) sets that channel's working code to `wdata[RES_BITS-1:0]`, visible on `dac_code` after the next edge. A read returns the code with every bit above RES_BITS at zero.
- R3: The working settings word is at address 08h. Channel c uses bits [5c+4:5c]: bits [1:0] are the reference (00 supply, 01 band gap, 10 external unbuffered, 11 external buffered), bits [3:2] are the power-down mode (00 normal, 01 100 k pull-down, 10 1 k pull-down, 11 high impedance) and bit 4 requests 2x gain. A write drives `ref_sel` and `pd_mode` after the next edge.
- R4: `gain_2x[c]` is the gain bit of channel c AND (reference of channel c is not 00). The stored gain bit reads back as written.
- R5: The shadow locations are 10h+c (code), 18h (settings word, same layout as 08h) and 1Ah (bus address, bits [6:0]). A shadow write that is accepted raises `nv_busy` for exactly NV_DELAY cycles. During that time the location still reads its old value. When `nv_busy` falls the new value is committed, and the working copies do not change.
- R6: A shadow write made while `nv_busy` is 1 is discarded, and it does not lengthen the busy time.
- R7: The status word is at address 0Ah. Bit 1 is the lock and is writable. Bit 0 mirrors `nv_busy` and ignores writes. While the lock is 1, shadow writes are discarded and `nv_busy` stays 0.
- R8: A cycle with `rst_n` low loads every working code and settings field from its shadow. It also clears the lock and `rdata`, aborts a pending shadow write and clears `nv_busy`. Writes in that cycle are ignored.
- R9: Addresses outside the map (for example 05h and 15h) read as 0. Writes to them change nothing and do not raise `nv_busy`.
- R10: `rdata` loads the addressed word at an edge where `rd_en` is 1, reflecting the state before that edge. At other times `rdata` holds its value.
- R11: `slave_addr` follows the committed shadow bus address, which reads back at 1Ah.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous cold start, active low; loads factory values into both copies |
| rst_n | input | 1 | Synchronous warm reset, active low; recalls working copies from shadows |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| dac_code | output | NUM_CH*RES_BITS | Working DAC code per channel, channel 0 in the low bits |
| ref_sel | output | 2*NUM_CH | Reference selection per channel |
| pd_mode | output | 2*NUM_CH | Power-down mode per channel |
| gain_2x | output | NUM_CH | Effective 2x gain per channel after the legality rule |
| nv_busy | output | 1 | Shadow programming in progress |
| slave_addr | output | 7 | Committed bus address |

## Verification
The assertions assume that `por_n` is low at time zero, so that no register holds an unknown value at the first checked edge. They also assume that `wr_en`, `rd_en`, `addr` and `wdata` change only away from the rising edge. The bench drives every input on the falling edge and holds `por_n` low for several cycles before it releases it. The random stimulus writes only mapped addresses, with arbitrary data. It always waits out the programming time after an accepted shadow write, except in the directed cases that write during busy time or reset during busy time on purpose.

// File: rtl/dac_cfg_pkg.sv
package dac_cfg_pkg;

   localparam int ADDR_W  = 5;
   localparam int DATA_W  = 16;
   localparam int FIELD_W = 5;

   localparam logic [ADDR_W-1:0] ADR_VCODE0 = 5'h00;
   localparam logic [ADDR_W-1:0] ADR_VSET   = 5'h08;
   localparam logic [ADDR_W-1:0] ADR_STAT   = 5'h0A;
   localparam logic [ADDR_W-1:0] ADR_NCODE0 = 5'h10;
   localparam logic [ADDR_W-1:0] ADR_NSET   = 5'h18;
   localparam logic [ADDR_W-1:0] ADR_NBUS   = 5'h1A;

   typedef enum logic [1:0] {
      REF_SUPPLY    = 2'b00,
      REF_BANDGAP   = 2'b01,
      REF_EXT_UNBUF = 2'b10,
      REF_EXT_BUF   = 2'b11
   } ref_sel_e;

   typedef enum logic [1:0] {
      PD_ACTIVE = 2'b00,
      PD_R100K  = 2'b01,
      PD_R1K    = 2'b10,
      PD_OPEN   = 2'b11
   } pd_mode_e;

   typedef struct packed {
      logic       gain;
      logic [1:0] pd;
      logic [1:0] refs;
   } chan_set_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic logic gain_allowed(input chan_set_t s);
      return s.gain && (s.refs != REF_SUPPLY);
   endfunction

endpackage

// File: rtl/dac_nv_seq.sv
module dac_nv_seq #(
   parameter int DELAY = 16,
   parameter int AW    = 5,
   parameter int DW    = 12
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          recall,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic [DW-1:0] start_data,
   output logic          busy,
   output logic          commit,
   output logic [AW-1:0] commit_addr,
   output logic [DW-1:0] commit_data
);

   localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
   localparam logic [CW-1:0] LOAD = CW'(DELAY);
   localparam logic [CW-1:0] LAST = CW'(1);

   logic [CW-1:0] remain_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         remain_q <= '0;
      end else if (recall) begin
         remain_q <= '0;
      end else if (start) begin
         remain_q <= LOAD;
      end else if (remain_q != '0) begin
         remain_q <= remain_q - LAST;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (start && !recall) begin
         addr_q <= start_addr;
         data_q <= start_data;
      end
   end

   assign busy        = (remain_q != '0);
   assign commit      = (remain_q == LAST) && !recall;
   assign commit_addr = addr_q;
   assign commit_data = data_q;

endmodule

// File: rtl/dac_chan_slice.sv
module dac_chan_slice
   import dac_cfg_pkg::*;
#(
   parameter int                RES_BITS     = 12,
   parameter logic [RES_BITS-1:0] FACTORY_CODE = '1
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                recall,
   input  logic                vol_code_we,
   input  logic                vol_set_we,
   input  logic [RES_BITS-1:0] wr_code,
   input  chan_set_t           wr_set,
   input  logic                nv_code_we,
   input  logic                nv_set_we,
   input  logic [RES_BITS-1:0] nv_code_d,
   input  chan_set_t           nv_set_d,
   output logic [RES_BITS-1:0] vol_code,
   output logic [RES_BITS-1:0] nv_code,
   output chan_set_t           vol_set,
   output chan_set_t           nv_set,
   output logic                eff_gain
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         nv_code <= FACTORY_CODE;
         nv_set  <= '0;
      end else begin
         if (nv_code_we) nv_code <= nv_code_d;
         if (nv_set_we)  nv_set  <= nv_set_d;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         vol_code <= FACTORY_CODE;
         vol_set  <= '0;
      end else if (recall) begin
         vol_code <= nv_code;
         vol_set  <= nv_set;
      end else begin
         if (vol_code_we) vol_code <= wr_code;
         if (vol_set_we)  vol_set  <= wr_set;
      end
   end

   assign eff_gain = gain_allowed(vol_set);

endmodule

// File: rtl/dac_cfg_bank.sv
module dac_cfg_bank
   import dac_cfg_pkg::*;
#(
   parameter int         RES_BITS      = 12,
   parameter int         NUM_CH        = 2,
   parameter int         NV_DELAY      = 16,
   parameter logic [6:0] SLAVE_DEFAULT = 7'h60
) (
   input  logic                       clk,
   input  logic                       por_n,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       rd_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   output logic [NUM_CH*RES_BITS-1:0] dac_code,
   output logic [2*NUM_CH-1:0]        ref_sel,
   output logic [2*NUM_CH-1:0]        pd_mode,
   output logic [NUM_CH-1:0]          gain_2x,
   output logic                       nv_busy,
   output logic [6:0]                 slave_addr
);

   localparam int SET_W  = FIELD_W * NUM_CH;
   localparam int USED_W = max3(RES_BITS, SET_W, 7);
   localparam logic [RES_BITS-1:0] FACTORY_CODE = RES_BITS'((1 << (RES_BITS - 1)) - 1);

   if (!(RES_BITS == 8 || RES_BITS == 10 || RES_BITS == 12)) begin : g_bad_res
      $error("dac_cfg_bank: RES_BITS must be 8, 10 or 12");
   end
   if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
      $error("dac_cfg_bank: NUM_CH must be 1 or 2");
   end
   if (NV_DELAY < 1) begin : g_bad_delay
      $error("dac_cfg_bank: NV_DELAY must be at least 1");
   end

   logic                       recall;
   logic                       wr_ok;
   logic                       wp_q;
   logic                       nv_loc_ok;
   logic                       nv_start;
   logic                       commit;
   logic [ADDR_W-1:0]          commit_addr;
   logic [USED_W-1:0]          commit_data;
   logic [6:0]                 bus_q;
   logic [DATA_W-1:0]          rd_mux;
   logic [RES_BITS-1:0]        vcode [NUM_CH];
   logic [RES_BITS-1:0]        ncode [NUM_CH];
   chan_set_t                  vset  [NUM_CH];
   chan_set_t                  nset  [NUM_CH];
   logic [NUM_CH*RES_BITS-1:0] ncode_flat;
   logic                       unused_wdata_hi;

   assign recall          = !rst_n;
   assign wr_ok           = wr_en && rst_n;
   assign unused_wdata_hi = ^wdata[DATA_W-1:USED_W];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wp_q <= 1'b0;
      end else if (recall) begin
         wp_q <= 1'b0;
      end else if (wr_ok && addr == ADR_STAT) begin
         wp_q <= wdata[1];
      end
   end

   always_comb begin
      nv_loc_ok = (addr == ADR_NSET) || (addr == ADR_NBUS);
      for (int c = 0; c < NUM_CH; c++) begin
         if (addr == ADR_NCODE0 + ADDR_W'(c)) nv_loc_ok = 1'b1;
      end
   end

   assign nv_start = wr_ok && nv_loc_ok && !wp_q && !nv_busy;

   dac_nv_seq #(
      .DELAY (NV_DELAY),
      .AW    (ADDR_W),
      .DW    (USED_W)
   ) u_seq (
      .clk         (clk),
      .por_n       (por_n),
      .recall      (recall),
      .start       (nv_start),
      .start_addr  (addr),
      .start_data  (wdata[USED_W-1:0]),
      .busy        (nv_busy),
      .commit      (commit),
      .commit_addr (commit_addr),
      .commit_data (commit_data)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] VA = ADR_VCODE0 + ADDR_W'(c);
      localparam logic [ADDR_W-1:0] NA = ADR_NCODE0 + ADDR_W'(c);

      logic eff_gain;

      dac_chan_slice #(
         .RES_BITS     (RES_BITS),
         .FACTORY_CODE (FACTORY_CODE)
      ) u_slice (
         .clk         (clk),
         .por_n       (por_n),
         .recall      (recall),
         .vol_code_we (wr_ok && addr == VA),
         .vol_set_we  (wr_ok && addr == ADR_VSET),
         .wr_code     (wdata[RES_BITS-1:0]),
         .wr_set      (chan_set_t'(wdata[c*FIELD_W +: FIELD_W])),
         .nv_code_we  (commit && commit_addr == NA),
         .nv_set_we   (commit && commit_addr == ADR_NSET),
         .nv_code_d   (commit_data[RES_BITS-1:0]),
         .nv_set_d    (chan_set_t'(commit_data[c*FIELD_W +: FIELD_W])),
         .vol_code    (vcode[c]),
         .nv_code     (ncode[c]),
         .vol_set     (vset[c]),
         .nv_set      (nset[c]),
         .eff_gain    (eff_gain)
      );

      assign dac_code[c*RES_BITS +: RES_BITS]   = vcode[c];
      assign ncode_flat[c*RES_BITS +: RES_BITS] = ncode[c];
      assign ref_sel[2*c +: 2]                  = vset[c].refs;
      assign pd_mode[2*c +: 2]                  = vset[c].pd;
      assign gain_2x[c]                         = eff_gain;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         bus_q <= SLAVE_DEFAULT;
      end else if (commit && commit_addr == ADR_NBUS) begin
         bus_q <= commit_data[6:0];
      end
   end

   assign slave_addr = bus_q;

   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (addr == ADR_VCODE0 + ADDR_W'(c)) rd_mux[RES_BITS-1:0] = vcode[c];
         if (addr == ADR_NCODE0 + ADDR_W'(c)) rd_mux[RES_BITS-1:0] = ncode[c];
         if (addr == ADR_VSET) rd_mux[c*FIELD_W +: FIELD_W] = vset[c];
         if (addr == ADR_NSET) rd_mux[c*FIELD_W +: FIELD_W] = nset[c];
      end
      if (addr == ADR_STAT) rd_mux[1:0] = {wp_q, nv_busy};
      if (addr == ADR_NBUS) rd_mux[6:0] = bus_q;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rdata <= '0;
      end else if (recall) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/dac_cfg_bank_chk.sv
module dac_cfg_bank_chk #(
   parameter int RES_BITS = 12,
   parameter int NUM_CH   = 2,
   parameter int NV_DELAY = 16
) (
   input logic                       clk,
   input logic                       por_n,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [4:0]                 addr,
   input logic [RES_BITS-1:0]        wdata_code,
   input logic [NUM_CH*RES_BITS-1:0] dac_code,
   input logic [2*NUM_CH-1:0]        ref_sel,
   input logic [NUM_CH-1:0]          gain_2x,
   input logic                       nv_busy,
   input logic                       wp_q,
   input logic [NUM_CH*RES_BITS-1:0] nv_code_flat
);

   int unsigned busy_len;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy_len <= 0;
      end else if (!rst_n || !nv_busy) begin
         busy_len <= 0;
      end else begin
         busy_len <= busy_len + 1;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      p_gain_legal_r4: assert property (@(posedge clk) disable iff (!por_n)
         (ref_sel[2*c +: 2] == 2'b00) |-> !gain_2x[c]);

      p_code_write_r2: assert property (@(posedge clk) disable iff (!por_n)
         (wr_en && rst_n && addr == 5'(c))
         |=> (dac_code[c*RES_BITS +: RES_BITS] == $past(wdata_code)));
   end

   p_recall_r8: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |=> (dac_code == $past(nv_code_flat)));

   p_lock_blocks_r7: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && rst_n && addr[4] && wp_q && !nv_busy) |=> !nv_busy);

   p_busy_len_r5: assert property (@(posedge clk) disable iff (!por_n)
      ($fell(nv_busy) && $past(rst_n)) |-> (busy_len == NV_DELAY));

   p_busy_cleared_r8: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |=> !nv_busy);

endmodule

bind dac_cfg_bank dac_cfg_bank_chk #(
   .RES_BITS (RES_BITS),
   .NUM_CH   (NUM_CH),
   .NV_DELAY (NV_DELAY)
) u_chk (
   .clk          (clk),
   .por_n        (por_n),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .addr         (addr),
   .wdata_code   (wdata[RES_BITS-1:0]),
   .dac_code     (dac_code),
   .ref_sel      (ref_sel),
   .gain_2x      (gain_2x),
   .nv_busy      (nv_busy),
   .wp_q         (wp_q),
   .nv_code_flat (ncode_flat)
);

// File: tb/dac_cfg_bank_tb.sv
module dac_cfg_bank_tb;

   localparam int RES = 12;
   localparam int NCH = 2;
   localparam int D   = 16;

   logic              clk = 1'b0;
   logic              por_n = 1'b0;
   logic              rst_n = 1'b1;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [4:0]        addr  = '0;
   logic [15:0]       wdata = '0;
   logic [15:0]       rdata;
   logic [NCH*RES-1:0] dac_code;
   logic [2*NCH-1:0]  ref_sel;
   logic [2*NCH-1:0]  pd_mode;
   logic [NCH-1:0]    gain_2x;
   logic              nv_busy;
   logic [6:0]        slave_addr;

   int checks = 0;
   int fails  = 0;

   logic [RES-1:0] m_v [NCH];
   logic [RES-1:0] m_n [NCH];
   logic [9:0]     m_vs, m_ns;
   logic           m_wp;
   logic [6:0]     m_bus;

   always #10 clk = ~clk;

   dac_cfg_bank u_dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .dac_code(dac_code),
      .ref_sel(ref_sel), .pd_mode(pd_mode), .gain_2x(gain_2x),
      .nv_busy(nv_busy), .slave_addr(slave_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

   function automatic logic exp_gain(input logic [4:0] s);
      return s[4] && (s[1:0] != 2'b00);
   endfunction

   function automatic logic [15:0] model_rd(input logic [4:0] a);
      case (a)
         5'h00: return 16'(m_v[0]);
         5'h01: return 16'(m_v[1]);
         5'h08: return 16'(m_vs);
         5'h0A: return {14'b0, m_wp, 1'b0};
         5'h10: return 16'(m_n[0]);
         5'h11: return 16'(m_n[1]);
         5'h18: return 16'(m_ns);
         5'h1A: return 16'(m_bus);
         default: return 16'h0000;
      endcase
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] v);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic warm_reset();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c < NCH; c++) m_v[c] = m_n[c];
      m_vs = m_ns;
      m_wp = 1'b0;
   endtask

   task automatic check_outs(input string tag);
      for (int c = 0; c < NCH; c++) begin
         chk({tag, " code"}, 32'(dac_code[c*RES +: RES]), 32'(m_v[c]));
         chk({tag, " ref"},  32'(ref_sel[2*c +: 2]), 32'(m_vs[5*c +: 2]));
         chk({tag, " pd"},   32'(pd_mode[2*c +: 2]), 32'(m_vs[5*c+2 +: 2]));
         chk({tag, " gain"}, 32'(gain_2x[c]), 32'(exp_gain(m_vs[5*c +: 5])));
      end
   endtask

   task automatic check_rd(input string tag, input logic [4:0] a);
      logic [15:0] v;
      rd(a, v);
      chk(tag, 32'(v), 32'(model_rd(a)));
   endtask

   task automatic nv_write(input logic [4:0] a, input logic [15:0] d);
      wr(a, d);
      chk("R5 busy raised", 32'(nv_busy), 32'(!m_wp));
      if (!m_wp) begin
         idle(D);
         chk("R5 busy cleared", 32'(nv_busy), 32'h0);
         case (a)
            5'h10: m_n[0] = d[RES-1:0];
            5'h11: m_n[1] = d[RES-1:0];
            5'h18: m_ns   = d[9:0];
            default: m_bus = d[6:0];
         endcase
      end else begin
         idle(D);
      end
   endtask

   initial begin
      logic [15:0] v;
      logic [15:0] held;
      logic [4:0]  rd_list [8];
      logic [4:0]  nv_list [4];
      rd_list = '{5'h00, 5'h01, 5'h08, 5'h0A, 5'h10, 5'h11, 5'h18, 5'h1A};
      nv_list = '{5'h10, 5'h11, 5'h18, 5'h1A};

      for (int c = 0; c < NCH; c++) begin
         m_v[c] = 12'h7FF; m_n[c] = 12'h7FF;
      end
      m_vs = '0; m_ns = '0; m_wp = 1'b0; m_bus = 7'h60;

      // R1 cold start
      idle(4);
      chk("R1 rdata in reset", 32'(rdata), 32'h0);
      por_n = 1'b1;
      idle(1);
      check_outs("R1");
      chk("R1 busy", 32'(nv_busy), 32'h0);
      chk("R1 slave", 32'(slave_addr), 32'h60);
      check_rd("R1 status", 5'h0A);
      check_rd("R1 shadow code0", 5'h10);

      // R2 code write masked
      wr(5'h00, 16'hFABC);
      m_v[0] = 12'hABC;
      check_outs("R2");
      rd(5'h00, v);
      chk("R2 readback upper zero", 32'(v), 32'h0ABC);

      // R3 settings word
      wr(5'h08, 16'h00BB);
      m_vs = 10'h0BB;
      check_outs("R3");
      check_rd("R3 readback", 5'h08);

      // R4 gain forced off with supply reference
      wr(5'h08, 16'h0010);
      m_vs = 10'h010;
      chk("R4 gain forced", 32'(gain_2x[0]), 32'h0);
      check_rd("R4 stored gain bit", 5'h08);

      // R5 shadow programming
      wr(5'h10, 16'h0123);
      chk("R5 busy set", 32'(nv_busy), 32'h1);
      rd(5'h10, v);
      chk("R5 old value during busy", 32'(v), 32'h7FF);
      idle(D - 2);
      chk("R5 busy still set", 32'(nv_busy), 32'h1);
      idle(1);
      chk("R5 busy falls", 32'(nv_busy), 32'h0);
      m_n[0] = 12'h123;
      check_rd("R5 committed", 5'h10);
      check_outs("R5 working untouched");

      // R6 reject during busy
      wr(5'h11, 16'h0456);
      wr(5'h11, 16'h0789);
      idle(D - 2);
      chk("R6 busy not extended (set)", 32'(nv_busy), 32'h1);
      idle(1);
      chk("R6 busy not extended (clear)", 32'(nv_busy), 32'h0);
      m_n[1] = 12'h456;
      check_rd("R6 first value kept", 5'h11);

      // R7 lock
      wr(5'h0A, 16'h0003);
      m_wp = 1'b1;
      check_rd("R7 busy bit read-only", 5'h0A);
      wr(5'h10, 16'h0555);
      chk("R7 no busy when locked", 32'(nv_busy), 32'h0);
      idle(D + 1);
      check_rd("R7 shadow unchanged", 5'h10);
      wr(5'h0A, 16'h0000);
      m_wp = 1'b0;

      // R9 reserved addresses
      wr(5'h05, 16'hFFFF);
      check_rd("R9 reserved reads zero", 5'h05);
      wr(5'h15, 16'hFFFF);
      chk("R9 reserved shadow no busy", 32'(nv_busy), 32'h0);
      check_outs("R9 outputs unchanged");

      // R10 rdata holds
      rd(5'h10, held);
      wr(5'h00, 16'h0001);
      m_v[0] = 12'h001;
      idle(3);
      chk("R10 rdata held", 32'(rdata), 32'(held));

      // R11 bus address
      nv_write(5'h1A, 16'h00FF);
      chk("R11 slave_addr", 32'(slave_addr), 32'h7F);
      check_rd("R11 readback", 5'h1A);

      // R8 recall, lock clear, abort
      wr(5'h0A, 16'h0002);
      m_wp = 1'b1;
      warm_reset();
      check_outs("R8 recall");
      chk("R8 rdata cleared", 32'(rdata), 32'h0);
      check_rd("R8 lock cleared", 5'h0A);
      wr(5'h18, 16'h03FF);
      warm_reset();
      chk("R8 busy aborted", 32'(nv_busy), 32'h0);
      idle(D + 2);
      check_rd("R8 aborted write lost", 5'h18);

      // random phase
      void'($urandom(32'h5EED1234));
      for (int i = 0; i < 300; i++) begin
         int op;
         op = int'($urandom % 8);
         case (op)
            0, 1: begin
               int c;
               logic [15:0] d;
               c = int'($urandom % NCH);
               d = 16'($urandom);
               wr(5'(c), d);
               m_v[c] = d[RES-1:0];
               check_outs("R2 random");
            end
            2: begin
               logic [15:0] d;
               d = 16'($urandom);
               wr(5'h08, d);
               m_vs = d[9:0];
               check_outs("R3 R4 random");
            end
            3, 4: check_rd("R10 random read", rd_list[$urandom % 8]);
            5: begin
               logic [15:0] d;
               d = 16'($urandom);
               wr(5'h0A, d);
               m_wp = d[1];
               check_rd("R7 random status", 5'h0A);
            end
            6: begin
               logic [4:0] a;
               a = nv_list[$urandom % 4];
               nv_write(a, 16'($urandom));
               check_rd("R5 R7 random shadow", a);
               chk("R11 random slave", 32'(slave_addr), 32'(m_bus));
            end
            default: begin
               warm_reset();
               check_outs("R8 random recall");
            end
         endcase
      end

      report();
      $finish;
   end

endmodule